// File: doc/BRIEF.md
# Shifted Operand Barrel Shifter

This block prepares the second operand of an integer ALU. It takes a 32-bit source value and moves it left, right (logically or with sign fill) or around (rotation) by an amount taken from either a 5-bit immediate field or the low byte of a second register value. It also produces the shifter carry, which is the last bit pushed out of the word, so that logical-class ALU operations can update the carry flag.

The block is purely combinational: the operand and carry settle in the same cycle as the inputs. Immediate amounts of zero carry special meanings per shift kind (pass-through, shift by the full word, one-bit rotate through carry). Register amounts of 32 and above follow fixed saturation rules. Decode, register reads and the ALU sit outside.

Top module: `bshift_operand`

## Requirements
- R1: Shift kind code 2'b00 selects logical left; for an amount n in 1..31 the result is the source moved n places toward the MSB with zeros in the low bits, and the carry is source bit 32-n.
- R2: Codes 2'b01 (logical right), 2'b10 (arithmetic right) and 2'b11 (rotate right) with n in 1..31 give the source moved n places toward the LSB, filled with zeros, copies of bit 31, or the bits that left the bottom respectively; the carry is source bit n-1.
- R3: In immediate mode (use_reg_amt=0), logical left by 0 returns the source unchanged with carry equal to carry_in.
- R4: In immediate mode, logical right by 0 acts as a shift by 32: result 0, carry equal to source bit 31.
- R5: In immediate mode, arithmetic right by 0 acts as a shift by 32: every result bit equals source bit 31 and so does the carry.
- R6: In immediate mode, rotate right by 0 is a one-bit rotate through carry: result {carry_in, src[31:1]}, carry src[0].
- R7: In register mode (use_reg_amt=1) the amount is amt_reg_val[7:0]; bits 31..8 have no effect.
- R8: A register amount of 0 returns the source and carry_in unchanged for all four kinds.
- R9: Register logical left or right by exactly 32 gives 0 with carry src[0] (left) or src[31] (right); by more than 32 gives 0 with carry 0.
- R10: Register arithmetic right by 32 or more gives all copies of bit 31, with carry equal to bit 31.
- R11: Register rotate right uses the amount modulo 32; a nonzero multiple of 32 returns the source with carry equal to bit 31.
- R12: In immediate mode amt_reg_val is ignored, and in register mode imm_amt is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_val | input | 32 | Value to be shifted |
| shift_kind | input | 2 | 00 left, 01 logical right, 10 arithmetic right, 11 rotate right |
| use_reg_amt | input | 1 | 1: amount from amt_reg_val low byte; 0: from imm_amt |
| imm_amt | input | 5 | Immediate shift amount 0..31 |
| amt_reg_val | input | 32 | Register value whose low byte holds the amount |
| carry_in | input | 1 | Current carry flag |
| operand_out | output | 32 | Shifted operand |
| carry_out | output | 1 | Shifter carry |

## Verification
Since nothing is stored, any fault in the amount decode or a shifter stage appears on operand_out or carry_out in the same cycle the inputs are applied. A wrong stage enable shows up as a result off by a power-of-two distance for every amount that uses that bit, and a wrong saturation or zero-amount rule shows up only at amounts 0, 32 and above, so the sweep covers every amount from 0 to 255 in both modes and every kind against a bit-serial model. A wrong carry selection usually leaves the result correct, so carry is compared on every vector.

// File: rtl/bshift_pkg.sv
package bshift_pkg;
  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ROR = 2'b11
  } shift_kind_e;
endpackage

// File: rtl/bshift_amount.sv
// Resolves the requested amount and the special cases into controls.
module bshift_amount
  import bshift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int IMM_W  = 5,
  parameter int SH_W   = 6,
  parameter int ROT_W  = 5
) (
  input  shift_kind_e        kind,
  input  logic               use_reg,
  input  logic [IMM_W-1:0]   imm_amt,
  input  logic [BYTE_W-1:0]  reg_amt,
  output logic               keep,
  output logic               rrx,
  output logic [SH_W-1:0]    lin_amt,
  output logic [ROT_W-1:0]   rot_amt
);
  localparam logic [BYTE_W-1:0] FULL_W = BYTE_W'(DATA_W);
  localparam logic [SH_W-1:0]   SAT_W  = SH_W'(DATA_W + 1);

  logic [BYTE_W-1:0] req_amt;
  logic              imm_zero;

  always_comb begin
    req_amt  = use_reg ? reg_amt : BYTE_W'(imm_amt);
    imm_zero = !use_reg && (imm_amt == '0);
    keep     = (use_reg && (reg_amt == '0)) || (imm_zero && (kind == SK_LSL));
    rrx      = imm_zero && (kind == SK_ROR);
    if (imm_zero)               lin_amt = SH_W'(DATA_W);
    else if (req_amt > FULL_W)  lin_amt = SAT_W;
    else                        lin_amt = SH_W'(req_amt);
    rot_amt  = req_amt[ROT_W-1:0];
  end
endmodule

// File: rtl/bshift_linear.sv
// Right shifter over {data, guard}; guard bit ends up holding the carry.
module bshift_linear #(
  parameter int DATA_W = 32,
  parameter int SH_W   = 6
) (
  input  logic [DATA_W-1:0] data,
  input  logic              fill,
  input  logic [SH_W-1:0]   amt,
  output logic [DATA_W-1:0] res,
  output logic              carry
);
  localparam int VW = DATA_W + 1;

  logic [VW-1:0] stage [0:SH_W];

  assign stage[0] = {data, 1'b0};

  for (genvar g = 0; g < SH_W; g++) begin : g_stage
    localparam int STEP = 1 << g;
    if (STEP < VW) begin : g_part
      assign stage[g+1] = amt[g] ? {{STEP{fill}}, stage[g][VW-1:STEP]} : stage[g];
    end else begin : g_all
      assign stage[g+1] = amt[g] ? {VW{fill}} : stage[g];
    end
  end

  assign res   = stage[SH_W][VW-1:1];
  assign carry = stage[SH_W][0];
endmodule

// File: rtl/bshift_rotate.sv
// Logarithmic right rotator.
module bshift_rotate #(
  parameter int DATA_W = 32,
  parameter int ROT_W  = 5
) (
  input  logic [DATA_W-1:0] data,
  input  logic [ROT_W-1:0]  amt,
  output logic [DATA_W-1:0] res
);
  logic [DATA_W-1:0] stage [0:ROT_W];

  assign stage[0] = data;

  for (genvar g = 0; g < ROT_W; g++) begin : g_stage
    localparam int STEP = (1 << g) % DATA_W;
    if (STEP == 0) begin : g_id
      assign stage[g+1] = stage[g];
    end else begin : g_rot
      assign stage[g+1] = amt[g] ? {stage[g][STEP-1:0], stage[g][DATA_W-1:STEP]} : stage[g];
    end
  end

  assign res = stage[ROT_W];
endmodule

// File: rtl/bshift_operand.sv
module bshift_operand
  import bshift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic [DATA_W-1:0]         src_val,
  input  logic [1:0]                shift_kind,
  input  logic                      use_reg_amt,
  input  logic [$clog2(DATA_W)-1:0] imm_amt,
  input  logic [DATA_W-1:0]         amt_reg_val,
  input  logic                      carry_in,
  output logic [DATA_W-1:0]         operand_out,
  output logic                      carry_out
);
  localparam int IMM_W = $clog2(DATA_W);
  localparam int ROT_W = IMM_W;
  localparam int SH_W  = $clog2(DATA_W + 2);

  shift_kind_e       kind;
  logic              keep, rrx;
  logic [SH_W-1:0]   lin_amt;
  logic [ROT_W-1:0]  rot_amt;
  logic [DATA_W-1:0] src_rev, lin_in, lin_res, lin_res_rev, rot_res;
  logic              lin_fill, lin_carry, go_left;

  assign kind    = shift_kind_e'(shift_kind);
  assign go_left = (kind == SK_LSL);

  bshift_amount #(
    .DATA_W(DATA_W), .BYTE_W(BYTE_W), .IMM_W(IMM_W), .SH_W(SH_W), .ROT_W(ROT_W)
  ) u_amount (
    .kind    (kind),
    .use_reg (use_reg_amt),
    .imm_amt (imm_amt),
    .reg_amt (amt_reg_val[BYTE_W-1:0]),
    .keep    (keep),
    .rrx     (rrx),
    .lin_amt (lin_amt),
    .rot_amt (rot_amt)
  );

  // Left shifts run through the right shifter on the bit-reversed word.
  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign src_rev[i]     = src_val[DATA_W-1-i];
    assign lin_res_rev[i] = lin_res[DATA_W-1-i];
  end

  assign lin_in   = go_left ? src_rev : src_val;
  assign lin_fill = (kind == SK_ASR) ? src_val[DATA_W-1] : 1'b0;

  bshift_linear #(.DATA_W(DATA_W), .SH_W(SH_W)) u_linear (
    .data  (lin_in),
    .fill  (lin_fill),
    .amt   (lin_amt),
    .res   (lin_res),
    .carry (lin_carry)
  );

  bshift_rotate #(.DATA_W(DATA_W), .ROT_W(ROT_W)) u_rotate (
    .data (src_val),
    .amt  (rot_amt),
    .res  (rot_res)
  );

  always_comb begin
    if (keep) begin
      operand_out = src_val;
      carry_out   = carry_in;
    end else if (rrx) begin
      operand_out = {carry_in, src_val[DATA_W-1:1]};
      carry_out   = src_val[0];
    end else if (kind == SK_ROR) begin
      operand_out = rot_res;
      carry_out   = rot_res[DATA_W-1];
    end else begin
      operand_out = go_left ? lin_res_rev : lin_res;
      carry_out   = lin_carry;
    end
  end
endmodule

// File: rtl/bshift_operand_chk.sv
module bshift_operand_chk #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input logic [DATA_W-1:0]         src_val,
  input logic [1:0]                shift_kind,
  input logic                      use_reg_amt,
  input logic [$clog2(DATA_W)-1:0] imm_amt,
  input logic [DATA_W-1:0]         amt_reg_val,
  input logic                      carry_in,
  input logic [DATA_W-1:0]         operand_out,
  input logic                      carry_out
);
  logic [BYTE_W-1:0] rb;
  logic              imm0;

  always_comb begin
    rb   = amt_reg_val[BYTE_W-1:0];
    imm0 = !use_reg_amt && (imm_amt == '0);

    if (use_reg_amt && rb == '0)
      assert_reg_zero_keeps_R8: assert (operand_out == src_val && carry_out == carry_in);

    if (imm0 && shift_kind == 2'b00)
      assert_imm_lsl_zero_R3: assert (operand_out == src_val && carry_out == carry_in);

    if (imm0 && shift_kind == 2'b01)
      assert_imm_lsr_zero_R4: assert (operand_out == '0 && carry_out == src_val[DATA_W-1]);

    if (shift_kind == 2'b10 && (imm0 || (use_reg_amt && rb >= BYTE_W'(DATA_W))))
      assert_asr_fill_R5_R10: assert (operand_out == {DATA_W{src_val[DATA_W-1]}}
                                       && carry_out == src_val[DATA_W-1]);

    if (imm0 && shift_kind == 2'b11)
      assert_rrx_R6: assert (operand_out == {carry_in, src_val[DATA_W-1:1]}
                             && carry_out == src_val[0]);

    if (use_reg_amt && !shift_kind[1] && rb > BYTE_W'(DATA_W))
      assert_reg_over_zero_R9: assert (operand_out == '0 && carry_out == 1'b0);

    if (shift_kind == 2'b11 && !imm0)
      assert_rotate_keeps_ones_R11: assert ($countones(operand_out) == $countones(src_val));

    if (shift_kind == 2'b01 && !use_reg_amt && imm_amt != '0)
      assert_lsr_top_clear_R2: assert (operand_out[DATA_W-1] == 1'b0);
  end
endmodule

bind bshift_operand bshift_operand_chk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (
  .src_val     (src_val),
  .shift_kind  (shift_kind),
  .use_reg_amt (use_reg_amt),
  .imm_amt     (imm_amt),
  .amt_reg_val (amt_reg_val),
  .carry_in    (carry_in),
  .operand_out (operand_out),
  .carry_out   (carry_out)
);

// File: tb/bshift_operand_tb.sv
module bshift_operand_tb;
  typedef struct packed {
    logic [1:0]  kind;
    logic        use_reg;
    logic [4:0]  imm;
    logic [31:0] regv;
    logic [31:0] src;
    logic        cin;
    logic [31:0] exp_res;
    logic        exp_c;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 19;
  localparam vec_t VECS [NVEC] = '{
    '{2'b00, 1'b0, 5'd4,  32'h0,         32'h0000_0001, 1'b1, 32'h0000_0010, 1'b0, 8'd1},  // R1
    '{2'b00, 1'b0, 5'd1,  32'h0,         32'h8000_0001, 1'b0, 32'h0000_0002, 1'b1, 8'd1},  // R1
    '{2'b01, 1'b0, 5'd4,  32'h0,         32'hF000_0000, 1'b1, 32'h0F00_0000, 1'b0, 8'd2},  // R2
    '{2'b10, 1'b0, 5'd1,  32'h0,         32'h8000_0000, 1'b1, 32'hC000_0000, 1'b0, 8'd2},  // R2
    '{2'b11, 1'b0, 5'd1,  32'h0,         32'h0000_0003, 1'b0, 32'h8000_0001, 1'b1, 8'd2},  // R2
    '{2'b00, 1'b0, 5'd0,  32'h0,         32'h1234_5678, 1'b1, 32'h1234_5678, 1'b1, 8'd3},  // R3
    '{2'b01, 1'b0, 5'd0,  32'h0,         32'h8000_0000, 1'b0, 32'h0000_0000, 1'b1, 8'd4},  // R4
    '{2'b10, 1'b0, 5'd0,  32'h0,         32'h8000_0000, 1'b0, 32'hFFFF_FFFF, 1'b1, 8'd5},  // R5
    '{2'b11, 1'b0, 5'd0,  32'h0,         32'h0000_0001, 1'b0, 32'h0000_0000, 1'b1, 8'd6},  // R6
    '{2'b11, 1'b0, 5'd0,  32'h0,         32'h0000_0002, 1'b1, 32'h8000_0001, 1'b0, 8'd6},  // R6
    '{2'b00, 1'b1, 5'd7,  32'h0000_0100, 32'hABCD_0000, 1'b0, 32'hABCD_0000, 1'b0, 8'd8},  // R8 with R7
    '{2'b00, 1'b1, 5'd0,  32'd32,        32'h0000_0001, 1'b0, 32'h0000_0000, 1'b1, 8'd9},  // R9
    '{2'b01, 1'b1, 5'd0,  32'd33,        32'hFFFF_FFFF, 1'b1, 32'h0000_0000, 1'b0, 8'd9},  // R9
    '{2'b01, 1'b1, 5'd0,  32'd32,        32'h8000_0000, 1'b0, 32'h0000_0000, 1'b1, 8'd9},  // R9
    '{2'b10, 1'b1, 5'd0,  32'd40,        32'h8000_0000, 1'b0, 32'hFFFF_FFFF, 1'b1, 8'd10}, // R10
    '{2'b11, 1'b1, 5'd0,  32'd64,        32'h8000_0001, 1'b0, 32'h8000_0001, 1'b1, 8'd11}, // R11
    '{2'b11, 1'b1, 5'd0,  32'd36,        32'h0000_00F0, 1'b1, 32'h0000_000F, 1'b0, 8'd11}, // R11
    '{2'b00, 1'b1, 5'd9,  32'hFFFF_FF04, 32'h0000_0001, 1'b1, 32'h0000_0010, 1'b0, 8'd7},  // R7
    '{2'b01, 1'b0, 5'd2,  32'h0000_0005, 32'h0000_0010, 1'b1, 32'h0000_0004, 1'b0, 8'd12}  // R12
  };

  logic        clk, rst_n;
  logic [31:0] src_val, amt_reg_val, operand_out;
  logic [1:0]  shift_kind;
  logic        use_reg_amt, carry_in, carry_out;
  logic [4:0]  imm_amt;
  int          n_chk, n_bad;
  bit          done;

  bshift_operand u_dut (
    .src_val     (src_val),
    .shift_kind  (shift_kind),
    .use_reg_amt (use_reg_amt),
    .imm_amt     (imm_amt),
    .amt_reg_val (amt_reg_val),
    .carry_in    (carry_in),
    .operand_out (operand_out),
    .carry_out   (carry_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Bit-serial model written from the requirements.
  function automatic logic [32:0] model(logic [31:0] s, logic [1:0] k, logic ur,
                                        logic [4:0] im, logic [31:0] rv, logic ci);
    logic [31:0] v;
    logic        c;
    int          a;
    v = s;
    c = ci;
    a = ur ? int'(rv[7:0]) : int'(im);
    if (a == 0) begin
      if (ur || k == 2'b00) return {ci, s};
      if (k == 2'b11) return {s[0], ci, s[31:1]};
      a = 32;
    end
    for (int i = 0; i < a; i++) begin
      case (k)
        2'b00:   begin c = v[31]; v = {v[30:0], 1'b0}; end
        2'b01:   begin c = v[0];  v = {1'b0, v[31:1]}; end
        2'b10:   begin c = v[0];  v = {v[31], v[31:1]}; end
        default: begin c = v[0];  v = {v[0], v[31:1]}; end
      endcase
    end
    return {c, v};
  endfunction

  task automatic apply(logic [31:0] s, logic [1:0] k, logic ur, logic [4:0] im,
                       logic [31:0] rv, logic ci);
    @(posedge clk);
    #1;
    src_val = s; shift_kind = k; use_reg_amt = ur; imm_amt = im; amt_reg_val = rv; carry_in = ci;
    @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] er, logic ec);
    n_chk++;
    if (operand_out !== er || carry_out !== ec) begin
      n_bad++;
      $display("FAIL %s: got res=%h c=%b expected res=%h c=%b (src=%h kind=%b reg=%b imm=%0d rv=%h cin=%b)",
               req, operand_out, carry_out, er, ec, src_val, shift_kind, use_reg_amt,
               imm_amt, amt_reg_val, carry_in);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got running expected done");
      finish_run();
    end
  end

  initial begin
    logic [32:0] m;
    logic [31:0] pats [4];
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0;
    pats[0] = 32'h8000_0001; pats[1] = 32'h7F3C_A5E1; pats[2] = 32'hFFFF_FFFF; pats[3] = 32'h1248_0C3D;

    // Idle inputs: all zero, immediate left by 0 returns zero and carry zero (R3).
    apply(32'h0, 2'b00, 1'b0, 5'd0, 32'h0, 1'b0);
    check("R3 idle", 32'h0, 1'b0);
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      apply(VECS[i].src, VECS[i].kind, VECS[i].use_reg, VECS[i].imm, VECS[i].regv, VECS[i].cin);
      check($sformatf("R%0d table row %0d", VECS[i].req, i), VECS[i].exp_res, VECS[i].exp_c);
    end

    // Sweep: R1 R2 R8 R9 R10 R11 over all amounts, with noise in ignored fields (R7 R12).
    for (int k = 0; k < 4; k++) begin
      for (int ur = 0; ur < 2; ur++) begin
        for (int a = 0; a < 256; a++) begin
          for (int p = 0; p < 4; p++) begin
            logic [31:0] rv;
            logic [4:0]  im;
            logic        ci;
            if (ur == 1) begin
              rv = {pats[p][31:8], 8'(a)};
              im = 5'(a) ^ 5'h15;
            end else begin
              if (a > 31) break;
              rv = pats[(p + 1) % 4];
              im = 5'(a);
            end
            ci = p[0];
            m = model(pats[p], 2'(k), 1'(ur), im, rv, ci);
            apply(pats[p], 2'(k), 1'(ur), im, rv, ci);
            check(ur == 1 ? "R7 R9 R10 R11 register sweep" : "R1 R2 R12 immediate sweep",
                  m[31:0], m[32]);
          end
        end
      end
    end

    // Upper register bits toggled with same low byte: result unchanged (R7).
    apply(32'hDEAD_BEEF, 2'b11, 1'b1, 5'd3, 32'h0000_0008, 1'b0);
    check("R7 low byte 8", 32'hEFDE_ADBE, 1'b1);
    apply(32'hDEAD_BEEF, 2'b11, 1'b1, 5'd3, 32'hFFFF_FF08, 1'b0);
    check("R7 upper bits set", 32'hEFDE_ADBE, 1'b1);
    // Register amount 255 on left shift: zero, carry clear (R9).
    apply(32'hFFFF_FFFF, 2'b00, 1'b1, 5'd0, 32'h0000_00FF, 1'b1);
    check("R9 amount 255", 32'h0, 1'b0);

    done = 1'b1;
    finish_run();
  end
endmodule